// File: doc/BRIEF.md
# Synchronous Trap Detection and Entry Sequencer

This unit sits next to an in-order CPU pipeline. It receives one strobe for each executed instruction, and the strobe comes with a decoded opcode class, an 8-bit immediate, a coprocessor index and the address of that instruction. The unit checks that strobe against several trap conditions: software interrupt, debug trap, single-step trace, access to an absent coprocessor, and a coprocessor error left from an earlier operation. It also accepts a non-maskable interrupt request. When more than one source is active, a fixed priority picks one. The unit then raises a single entry pulse that carries the handler vector number and the return address.

Coprocessor errors do not trap when they occur. Each coprocessor has its own pending flag, which the error report sets. The trap fires only when a later operate, load or store instruction addresses the same coprocessor. The unit also holds the interrupt-enable and stack-select status bits. It copies them into a saved pair on each trap entry and copies them back when it sees the return-from-trap input.

Top module: `trap_entry_unit`

## Requirements
- R1: For a trap caused by an issued instruction, trap_ret_addr equals issue_pc + INSN_BYTES (default 2). trap_take, trap_vec and trap_ret_addr appear one clock after the strobe.
- R2: issue_class 1 (software interrupt) takes a trap whose vector equals issue_imm.
- R3: A trap entry for NMI, software interrupt, coprocessor-absent or coprocessor-error clears ie and stk_sel. stk_sel 0 selects the system stack.
- R4: Every trap entry copies the current ie and stk_sel into saved_ie and saved_stk. When trap_return is high and no trap is taken in that cycle, ie and stk_sel are loaded from the saved pair. In a cycle where a trap is taken, trap_return is ignored.
- R5: Classes 3 (operate), 4 (load), 5 (store) and 6 (save) address coprocessor issue_cop. If cop_present[issue_cop] is 0, the unit takes a trap with vector VEC_CABS (default 0x0D).
- R6: A pulse on cop_err_set[i] marks coprocessor i as having an error pending. Only an operate, load or store instruction to coprocessor i then takes a trap with vector VEC_CERR (default 0x0E). Save instructions and instructions to other coprocessors do not take this trap.
- R7: A pending error is cleared only when its error trap is actually taken. If a higher-priority source wins instead, the error stays pending.
- R8: While trace_en is high, every issued instruction that raises no other trap takes a step trap with vector VEC_STEP (default 0x0C). This trap leaves ie and stk_sel unchanged. With trace_en low, a plain instruction (class 0) takes no trap.
- R9: issue_class 2 takes a debug trap with vector VEC_DBG (default 0x09). This trap leaves ie and stk_sel unchanged.
- R10: Priority, highest first: NMI, coprocessor error, coprocessor absent, software interrupt or debug trap, step trace. Only one trap is taken per cycle.
- R11: nmi_req takes a trap with vector VEC_NMI (default 0x0F). The return address is issue_pc + INSN_BYTES when an instruction is issued in that cycle, and issue_pc otherwise.
- R12: After reset, trap_take is 0 and ie, stk_sel, saved_ie and saved_stk all equal 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | One executed instruction in this cycle |
| issue_class | input | 3 | Decoded opcode class (0 plain, 1 swi, 2 debug, 3-6 coprocessor op/load/store/save) |
| issue_imm | input | 8 | Software interrupt immediate |
| issue_cop | input | 2 | Addressed coprocessor index |
| issue_pc | input | 32 | Address of the issued instruction, or the next pc when idle |
| cop_present | input | 4 | Presence bit per coprocessor |
| cop_err_set | input | 4 | Error report pulse per coprocessor |
| trace_en | input | 1 | Step trace flag |
| nmi_req | input | 1 | Non-maskable interrupt request |
| trap_return | input | 1 | Return-from-trap strobe |
| trap_take | output | 1 | Trap entry pulse |
| trap_vec | output | 8 | Winning vector number |
| trap_ret_addr | output | 32 | Saved return address |
| ie | output | 1 | Global interrupt enable |
| stk_sel | output | 1 | Stack select (0 system, 1 user) |
| saved_ie | output | 1 | Interrupt enable saved on entry |
| saved_stk | output | 1 | Stack select saved on entry |

## Verification
Every result of this block appears exactly one clock after the inputs that cause it. This covers the entry pulse, the vector, the return address, the status bits and the saved pair. The driver applies inputs on the falling edge and pushes the expected values for that cycle into a queue. The monitor pops and compares that item one time unit after the next rising edge. Pending coprocessor errors are only visible through later traps, so the bench checks them by issuing further instructions to the same coprocessor and to a different one.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef enum logic [2:0] {
    OPC_PLAIN    = 3'd0,
    OPC_SWI      = 3'd1,
    OPC_DBG      = 3'd2,
    OPC_COP_OP   = 3'd3,
    OPC_COP_LD   = 3'd4,
    OPC_COP_ST   = 3'd5,
    OPC_COP_SAVE = 3'd6
  } opc_e;

  typedef enum logic [2:0] {
    TK_NONE,
    TK_NMI,
    TK_CERR,
    TK_CABS,
    TK_SWI,
    TK_DBG,
    TK_STEP
  } trap_kind_e;

  function automatic logic kind_masks(trap_kind_e k);
    return (k == TK_NMI) || (k == TK_CERR) || (k == TK_CABS) || (k == TK_SWI);
  endfunction
endpackage

// File: rtl/trap_cop_track.sv
module trap_cop_track
  import trap_pkg::*;
#(
  parameter int NCOP = 4,
  localparam int CW = (NCOP > 1) ? $clog2(NCOP) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue_valid,
  input  logic [2:0]      issue_class,
  input  logic [CW-1:0]   issue_cop,
  input  logic [NCOP-1:0] cop_present,
  input  logic [NCOP-1:0] cop_err_set,
  input  logic            err_taken,
  output logic            absent_hit,
  output logic            err_hit,
  output logic [NCOP-1:0] pend_q
);
  logic is_cop, err_elig;
  logic [NCOP-1:0] pend_d;

  always_comb begin
    is_cop   = (issue_class == OPC_COP_OP) || (issue_class == OPC_COP_LD) ||
               (issue_class == OPC_COP_ST) || (issue_class == OPC_COP_SAVE);
    err_elig = (issue_class == OPC_COP_OP) || (issue_class == OPC_COP_LD) ||
               (issue_class == OPC_COP_ST);
    absent_hit = issue_valid && is_cop && !cop_present[issue_cop];
    err_hit    = issue_valid && err_elig && pend_q[issue_cop];
  end

  for (genvar i = 0; i < NCOP; i++) begin : g_pend
    logic clr;
    always_comb begin
      clr       = err_taken && (issue_cop == CW'(i));
      pend_d[i] = cop_err_set[i] || (pend_q[i] && !clr);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q[i] <= 1'b0;
      else        pend_q[i] <= pend_d[i];
    end
  end
endmodule

// File: rtl/trap_arbiter.sv
module trap_arbiter
  import trap_pkg::*;
#(
  parameter logic [7:0] VEC_NMI  = 8'h0F,
  parameter logic [7:0] VEC_CERR = 8'h0E,
  parameter logic [7:0] VEC_CABS = 8'h0D,
  parameter logic [7:0] VEC_STEP = 8'h0C,
  parameter logic [7:0] VEC_DBG  = 8'h09
) (
  input  logic       nmi_req,
  input  logic       err_hit,
  input  logic       absent_hit,
  input  logic       swi_hit,
  input  logic       dbg_hit,
  input  logic       step_hit,
  input  logic [7:0] imm,
  output trap_kind_e kind,
  output logic [7:0] vec
);
  always_comb begin
    kind = TK_NONE;
    vec  = 8'h00;
    if (nmi_req) begin
      kind = TK_NMI;  vec = VEC_NMI;
    end else if (err_hit) begin
      kind = TK_CERR; vec = VEC_CERR;
    end else if (absent_hit) begin
      kind = TK_CABS; vec = VEC_CABS;
    end else if (swi_hit) begin
      kind = TK_SWI;  vec = imm;
    end else if (dbg_hit) begin
      kind = TK_DBG;  vec = VEC_DBG;
    end else if (step_hit) begin
      kind = TK_STEP; vec = VEC_STEP;
    end
  end
endmodule

// File: rtl/trap_status.sv
module trap_status
  import trap_pkg::*;
#(
  parameter logic RST_IE  = 1'b1,
  parameter logic RST_STK = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  trap_kind_e kind,
  input  logic       trap_return,
  output logic       ie_q,
  output logic       stk_q,
  output logic       sie_q,
  output logic       sstk_q
);
  logic take, ie_d, stk_d, sav_en, st_en;

  always_comb begin
    take   = (kind != TK_NONE);
    sav_en = take;
    st_en  = take || trap_return;
    ie_d   = ie_q;
    stk_d  = stk_q;
    if (take) begin
      if (kind_masks(kind)) begin
        ie_d  = 1'b0;
        stk_d = 1'b0;
      end
    end else if (trap_return) begin
      ie_d  = sie_q;
      stk_d = sstk_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q  <= RST_IE;
      stk_q <= RST_STK;
    end else if (st_en) begin
      ie_q  <= ie_d;
      stk_q <= stk_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sie_q  <= RST_IE;
      sstk_q <= RST_STK;
    end else if (sav_en) begin
      sie_q  <= ie_q;
      sstk_q <= stk_q;
    end
  end
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_pkg::*;
#(
  parameter int         NCOP       = 4,
  parameter int         AW         = 32,
  parameter int         INSN_BYTES = 2,
  parameter logic [7:0] VEC_NMI    = 8'h0F,
  parameter logic [7:0] VEC_CERR   = 8'h0E,
  parameter logic [7:0] VEC_CABS   = 8'h0D,
  parameter logic [7:0] VEC_STEP   = 8'h0C,
  parameter logic [7:0] VEC_DBG    = 8'h09,
  parameter logic       RST_IE     = 1'b1,
  parameter logic       RST_STK    = 1'b1,
  localparam int        CW         = (NCOP > 1) ? $clog2(NCOP) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue_valid,
  input  logic [2:0]      issue_class,
  input  logic [7:0]      issue_imm,
  input  logic [CW-1:0]   issue_cop,
  input  logic [AW-1:0]   issue_pc,
  input  logic [NCOP-1:0] cop_present,
  input  logic [NCOP-1:0] cop_err_set,
  input  logic            trace_en,
  input  logic            nmi_req,
  input  logic            trap_return,
  output logic            trap_take,
  output logic [7:0]      trap_vec,
  output logic [AW-1:0]   trap_ret_addr,
  output logic            ie,
  output logic            stk_sel,
  output logic            saved_ie,
  output logic            saved_stk
);
  logic rst_m, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_q <= rst_m;
    end
  end

  logic            absent_hit, err_hit, swi_hit, dbg_hit, step_hit;
  logic [NCOP-1:0] pend_q;
  trap_kind_e      kind;
  logic [7:0]      vec_d;
  logic [AW-1:0]   ret_d;

  always_comb begin
    swi_hit  = issue_valid && (issue_class == OPC_SWI);
    dbg_hit  = issue_valid && (issue_class == OPC_DBG);
    step_hit = issue_valid && trace_en;
    ret_d    = issue_valid ? issue_pc + AW'(INSN_BYTES) : issue_pc;
  end

  trap_cop_track #(.NCOP(NCOP)) u_cop (
    .clk(clk), .rst_n(rst_q),
    .issue_valid(issue_valid), .issue_class(issue_class), .issue_cop(issue_cop),
    .cop_present(cop_present), .cop_err_set(cop_err_set),
    .err_taken(kind == TK_CERR),
    .absent_hit(absent_hit), .err_hit(err_hit), .pend_q(pend_q)
  );

  trap_arbiter #(
    .VEC_NMI(VEC_NMI), .VEC_CERR(VEC_CERR), .VEC_CABS(VEC_CABS),
    .VEC_STEP(VEC_STEP), .VEC_DBG(VEC_DBG)
  ) u_arb (
    .nmi_req(nmi_req), .err_hit(err_hit), .absent_hit(absent_hit),
    .swi_hit(swi_hit), .dbg_hit(dbg_hit), .step_hit(step_hit),
    .imm(issue_imm), .kind(kind), .vec(vec_d)
  );

  trap_status #(.RST_IE(RST_IE), .RST_STK(RST_STK)) u_stat (
    .clk(clk), .rst_n(rst_q), .kind(kind), .trap_return(trap_return),
    .ie_q(ie), .stk_q(stk_sel), .sie_q(saved_ie), .sstk_q(saved_stk)
  );

  logic take_en;
  always_comb take_en = (kind != TK_NONE);

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) trap_take <= 1'b0;
    else        trap_take <= take_en;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      trap_vec      <= 8'h00;
      trap_ret_addr <= '0;
    end else if (take_en) begin
      trap_vec      <= vec_d;
      trap_ret_addr <= ret_d;
    end
  end
endmodule

module trap_entry_unit_chk #(
  parameter int         NCOP       = 4,
  parameter int         AW         = 32,
  parameter int         INSN_BYTES = 2,
  parameter logic [7:0] VEC_NMI    = 8'h0F,
  parameter logic [7:0] VEC_CABS   = 8'h0D,
  parameter logic [7:0] VEC_STEP   = 8'h0C,
  parameter logic [7:0] VEC_DBG    = 8'h09,
  localparam int        CW         = (NCOP > 1) ? $clog2(NCOP) : 1
) (
  input logic            clk,
  input logic            rst_ok,
  input logic            issue_valid,
  input logic [2:0]      issue_class,
  input logic [7:0]      issue_imm,
  input logic [CW-1:0]   issue_cop,
  input logic [AW-1:0]   issue_pc,
  input logic [NCOP-1:0] cop_present,
  input logic [NCOP-1:0] pend,
  input logic            trace_en,
  input logic            nmi_req,
  input logic            trap_return,
  input logic            trap_take,
  input logic [7:0]      trap_vec,
  input logic [AW-1:0]   trap_ret_addr,
  input logic            ie,
  input logic            stk_sel,
  input logic            saved_ie,
  input logic            saved_stk
);
  logic swi_now, dbg_now, abs_now;
  always_comb begin
    swi_now = issue_valid && issue_class == 3'd1 && !nmi_req;
    dbg_now = issue_valid && issue_class == 3'd2 && !nmi_req && !trace_en;
    abs_now = issue_valid && issue_class >= 3'd3 && issue_class <= 3'd6 &&
              !cop_present[issue_cop] && !pend[issue_cop] && !nmi_req;
  end

  assert_swi_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    swi_now |=> trap_take && trap_vec == $past(issue_imm));

  assert_swi_addr_R1: assert property (@(posedge clk) disable iff (!rst_ok)
    swi_now |=> trap_ret_addr == $past(issue_pc) + AW'(INSN_BYTES));

  assert_mask_R3: assert property (@(posedge clk) disable iff (!rst_ok)
    swi_now |=> !ie && !stk_sel);

  assert_restore_R4: assert property (@(posedge clk) disable iff (!rst_ok)
    (trap_return && !nmi_req && !issue_valid) |=>
      ie == $past(saved_ie) && stk_sel == $past(saved_stk));

  assert_absent_R5: assert property (@(posedge clk) disable iff (!rst_ok)
    abs_now |=> trap_take && trap_vec == VEC_CABS);

  assert_trace_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    (issue_valid && trace_en) |=> trap_take);

  assert_step_keep_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    (issue_valid && trace_en && issue_class == 3'd0 && !nmi_req) |=>
      trap_vec == VEC_STEP && $stable(ie) && $stable(stk_sel));

  assert_dbg_R9: assert property (@(posedge clk) disable iff (!rst_ok)
    dbg_now |=> trap_vec == VEC_DBG && $stable(ie) && $stable(stk_sel));

  assert_nmi_R11: assert property (@(posedge clk) disable iff (!rst_ok)
    nmi_req |=> trap_take && trap_vec == VEC_NMI);

  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_ok)
    (!issue_valid && !nmi_req) |=> !trap_take);
endmodule

bind trap_entry_unit trap_entry_unit_chk #(
  .NCOP(NCOP), .AW(AW), .INSN_BYTES(INSN_BYTES), .VEC_NMI(VEC_NMI),
  .VEC_CABS(VEC_CABS), .VEC_STEP(VEC_STEP), .VEC_DBG(VEC_DBG)
) u_chk (
  .clk(clk), .rst_ok(rst_q), .issue_valid(issue_valid), .issue_class(issue_class),
  .issue_imm(issue_imm), .issue_cop(issue_cop), .issue_pc(issue_pc),
  .cop_present(cop_present), .pend(pend_q), .trace_en(trace_en), .nmi_req(nmi_req),
  .trap_return(trap_return), .trap_take(trap_take), .trap_vec(trap_vec),
  .trap_ret_addr(trap_ret_addr), .ie(ie), .stk_sel(stk_sel),
  .saved_ie(saved_ie), .saved_stk(saved_stk)
);

// File: tb/trap_entry_unit_test.sv
module trap_entry_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_valid = 1'b0;
  logic [2:0]  issue_class = '0;
  logic [7:0]  issue_imm = '0;
  logic [1:0]  issue_cop = '0;
  logic [31:0] issue_pc = '0;
  logic [3:0]  cop_present = 4'b0111;
  logic [3:0]  cop_err_set = '0;
  logic        trace_en = 1'b0, nmi_req = 1'b0, trap_return = 1'b0;
  logic        trap_take, ie, stk_sel, saved_ie, saved_stk;
  logic [7:0]  trap_vec;
  logic [31:0] trap_ret_addr;

  always #2.5 clk = ~clk;

  trap_entry_unit uut (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_class(issue_class),
    .issue_imm(issue_imm), .issue_cop(issue_cop), .issue_pc(issue_pc),
    .cop_present(cop_present), .cop_err_set(cop_err_set), .trace_en(trace_en),
    .nmi_req(nmi_req), .trap_return(trap_return), .trap_take(trap_take),
    .trap_vec(trap_vec), .trap_ret_addr(trap_ret_addr), .ie(ie), .stk_sel(stk_sel),
    .saved_ie(saved_ie), .saved_stk(saved_stk)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct {
    logic take; logic [7:0] vec; logic [31:0] addr;
    logic ie, stk, sie, sstk;
  } exp_t;
  exp_t  q[$];
  string tq[$];

  logic       m_ie = 1, m_stk = 1, m_sie = 1, m_sstk = 1;
  logic [3:0] m_pend = '0;

  task automatic drive(input string tag, input bit v, input int cls, input int imm,
                       input int cop, input int pc, input bit [3:0] es,
                       input bit tr, input bit nmi, input bit ret);
    exp_t e;
    bit is_cop, elig, masks;
    @(negedge clk);
    issue_valid = v; issue_class = 3'(cls); issue_imm = 8'(imm);
    issue_cop = 2'(cop); issue_pc = 32'(pc); cop_err_set = es;
    trace_en = tr; nmi_req = nmi; trap_return = ret;
    is_cop = cls >= 3 && cls <= 6;
    elig   = cls >= 3 && cls <= 5;
    e.take = 1; e.vec = 0; masks = 0;
    e.addr = v ? 32'(pc + 2) : 32'(pc);
    if (nmi) begin e.vec = 8'h0F; masks = 1; end
    else if (v && elig && m_pend[cop]) begin e.vec = 8'h0E; masks = 1; m_pend[cop] = 0; end
    else if (v && is_cop && !cop_present[cop]) begin e.vec = 8'h0D; masks = 1; end
    else if (v && cls == 1) begin e.vec = 8'(imm); masks = 1; end
    else if (v && cls == 2) e.vec = 8'h09;
    else if (v && tr) e.vec = 8'h0C;
    else e.take = 0;
    if (e.take) begin
      m_sie = m_ie; m_sstk = m_stk;
      if (masks) begin m_ie = 0; m_stk = 0; end
    end else if (ret) begin
      m_ie = m_sie; m_stk = m_sstk;
    end
    m_pend = m_pend | es;
    e.ie = m_ie; e.stk = m_stk; e.sie = m_sie; e.sstk = m_sstk;
    q.push_back(e); tq.push_back(tag);
  endtask

  task automatic idle(input string tag);
    drive(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin : monitor
    exp_t e;
    string t;
    forever begin
      @(posedge clk); #1;
      if (q.size() > 0) begin
        e = q.pop_front(); t = tq.pop_front();
        checks++;
        if (trap_take !== e.take || ie !== e.ie || stk_sel !== e.stk ||
            saved_ie !== e.sie || saved_stk !== e.sstk ||
            (e.take && (trap_vec !== e.vec || trap_ret_addr !== e.addr))) begin
          errors++;
          $display("FAIL %s: got take=%b vec=%h addr=%h ie=%b stk=%b sie=%b sstk=%b exp take=%b vec=%h addr=%h ie=%b stk=%b sie=%b sstk=%b",
                   t, trap_take, trap_vec, trap_ret_addr, ie, stk_sel, saved_ie, saved_stk,
                   e.take, e.vec, e.addr, e.ie, e.stk, e.sie, e.sstk);
        end
      end
    end
  end

  initial begin : watchdog
    #(5 * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    checks++;  // R12 reset state
    if (trap_take !== 0 || ie !== 1 || stk_sel !== 1 || saved_ie !== 1 || saved_stk !== 1) begin
      errors++;
      $display("FAIL R12: got take=%b ie=%b stk=%b sie=%b sstk=%b expected 0 1 1 1 1",
               trap_take, ie, stk_sel, saved_ie, saved_stk);
    end
    drive("R8 plain no trace", 1, 0, 0, 0, 'h80, 0, 0, 0, 0);
    drive("R2 R1 R3 swi", 1, 1, 'h40, 0, 'h100, 0, 0, 0, 0);
    drive("R4 return", 0, 0, 0, 0, 0, 0, 0, 0, 1);
    drive("R5 absent op", 1, 3, 0, 3, 'h200, 0, 0, 0, 0);
    drive("R4 return", 0, 0, 0, 0, 0, 0, 0, 0, 1);
    drive("R5 absent save", 1, 6, 0, 3, 'h210, 0, 0, 0, 0);
    drive("R4 return", 0, 0, 0, 0, 0, 0, 0, 0, 1);
    drive("R6 err report", 1, 0, 0, 0, 'h300, 4'b0010, 0, 0, 0);
    drive("R6 other cop", 1, 3, 0, 2, 'h302, 0, 0, 0, 0);
    drive("R6 save ignored", 1, 6, 0, 1, 'h304, 0, 0, 0, 0);
    drive("R6 load traps", 1, 4, 0, 1, 'h306, 0, 0, 0, 0);
    drive("R4 return", 0, 0, 0, 0, 0, 0, 0, 0, 1);
    drive("R7 cleared", 1, 5, 0, 1, 'h308, 0, 0, 0, 0);
    drive("R7 err report", 0, 0, 0, 0, 0, 4'b0001, 0, 0, 0);
    drive("R10 R7 nmi wins", 1, 3, 0, 0, 'h400, 0, 0, 1, 0);
    drive("R4 return", 0, 0, 0, 0, 0, 0, 0, 0, 1);
    drive("R7 still pending", 1, 3, 0, 0, 'h402, 0, 0, 0, 0);
    drive("R4 return", 0, 0, 0, 0, 0, 0, 0, 0, 1);
    drive("R10 err report", 0, 0, 0, 0, 0, 4'b1000, 0, 0, 0);
    drive("R10 err over absent", 1, 3, 0, 3, 'h500, 0, 0, 0, 0);
    drive("R4 return", 0, 0, 0, 0, 0, 0, 0, 0, 1);
    drive("R11 nmi with insn", 1, 1, 'h22, 0, 'h600, 0, 0, 1, 0);
    drive("R4 return", 0, 0, 0, 0, 0, 0, 0, 0, 1);
    drive("R11 nmi idle", 0, 0, 0, 0, 'h700, 0, 0, 1, 0);
    drive("R4 return", 0, 0, 0, 0, 0, 0, 0, 0, 1);
    drive("R8 step", 1, 0, 0, 0, 'h800, 0, 1, 0, 0);
    drive("R10 swi over step", 1, 1, 'h33, 0, 'h802, 0, 1, 0, 0);
    drive("R9 dbg keeps status", 1, 2, 0, 0, 'h900, 0, 0, 0, 0);
    drive("R4 return nested", 0, 0, 0, 0, 0, 0, 0, 0, 1);
    drive("R4 return ignored on take", 1, 1, 'h55, 0, 'hA00, 0, 0, 0, 1);
    drive("R4 return", 0, 0, 0, 0, 0, 0, 0, 0, 1);
    drive("R9 dbg unmasked", 1, 2, 0, 0, 'hB00, 0, 0, 0, 0);
    drive("R8 step absent cop", 1, 4, 0, 3, 'hC00, 0, 1, 0, 0);
    idle("R10 idle");
    idle("R10 idle");
    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule